// File: doc/BRIEF.md
# Seconds Counter with Alarm and Trimmed One-Hertz Prescaler

This block keeps wall-clock time as a plain count of seconds. It runs entirely on the 32.768 kHz reference clock. A prescaler divides that clock down to a one-cycle tick once per second, and each tick advances a seconds counter. A programmable divide value sets the tick period. A small trim value lengthens one tick period out of every fixed number of seconds, so a slightly fast crystal can be pulled back into line.

Software reaches the block through a word-wide register port with a combinational read path and single-cycle writes. It can load the counter, set an alarm value, and program the divide and trim values. It also manages a status word. That word holds two event flags, one for the tick and one for the alarm, which are cleared by writing one to them. It also holds two interrupt enables that read and write normally. Each event has its own interrupt output, and each output is high while its flag and its enable are both set.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the count, status and divide/trim registers read zero, and both interrupt outputs are low.
- R2: The alarm register reads back the full written word. The divide/trim register (word 3) reads back bits 25:0 as written, with the divide value in bits 15:0 and the trim value in bits 25:16, and bits 31:26 read zero.
- R3: With a nonzero divide value D and zero trim, a tick occurs every D+1 reference clocks, and ticks are never back to back.
- R4: A divide value of zero gives one tick every 32768 reference clocks.
- R5: With trim T, one tick period out of every TRIM_PERIOD consecutive periods is T clocks longer, and the others are D+1.
- R6: A write to word 0 loads the counter. The value then rises by one on each later tick. If the load and a tick fall in the same cycle, the loaded value is kept.
- R7: Status bit 1 (tick flag) sets on every tick. Writing 1 to bit 1 clears it. Writing 0 to it leaves it set.
- R8: Status bit 0 (alarm flag) sets when a tick advances the counter to the value in word 1. Loading the counter with that value does not set it. Writing 1 to bit 0 clears it.
- R9: Status bits 3 (tick enable) and 2 (alarm enable) are read/write. The tick interrupt is high exactly when bits 1 and 3 are set, and the alarm interrupt is high exactly when bits 0 and 2 are set.
- R10: When a flag's set event and a write-one clear of that flag land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word select: 0 count, 1 alarm, 2 status, 3 divide/trim |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected word (combinational) |
| irq_tick_o | output | 1 | One-hertz interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |

## Verification
A tick and a bus write can land on the same reference clock edge. A tick competes with a load of the counter, and a tick also competes with a write-one clear of the tick flag. With a divide value of 3 the tick period is exactly four clocks. The bench locks onto a counter change and then times its write so that the write strobe sits on the fourth edge after it. It then judges the result by reading the counter or the status word at once, and again one tick later. That checks that the load survives and counting resumes from it, and that the flag stays set. A control write one cycle later shows that the clear takes effect when nothing competes with it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_ALARM = 2'd1,
    REG_STAT  = 2'd2,
    REG_TRIM  = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_AL  = 0;
  localparam int unsigned ST_HZ  = 1;
  localparam int unsigned ST_W   = 4;
  localparam int unsigned EVT_N  = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_W      = 10,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned DEFAULT_DIV = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              tick_o
);
  localparam int unsigned LIM_W  = DIV_W + 1;
  localparam int unsigned TCNT_W = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;

  logic [LIM_W-1:0]  cnt_q, base, ext, limit;
  logic [TCNT_W-1:0] tcnt_q;
  logic              trim_slot;

  assign trim_slot = (tcnt_q == TCNT_W'(TRIM_PERIOD - 1));
  assign base      = (div_i == '0) ? LIM_W'(DEFAULT_DIV) : {1'b0, div_i};
  assign ext       = trim_slot ? LIM_W'(trim_i) : '0;
  assign limit     = base + ext;
  // >= so a divide value lowered mid-count still terminates the period
  assign tick_o    = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tcnt_q <= '0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      tcnt_q <= trim_slot ? '0 : tcnt_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  logic [CNT_W-1:0] count_q, next_cnt;

  assign next_cnt = count_q + CNT_W'(1);
  // compare only on a counting update; a load never fires the alarm
  assign match_o  = tick_i && !load_i && (next_cnt == alarm_i);
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (tick_i) count_q <= next_cnt;
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EVT_N-1:0] set_i,
  input  logic            wr_i,
  input  logic [ST_W-1:0] wdata_i,
  output logic [ST_W-1:0] status_o
);
  logic [EVT_N-1:0] evt_q;
  logic [EVT_N-1:0] en_q;

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     evt_q[i] <= 1'b0;
      else if (set_i[i])               evt_q[i] <= 1'b1;  // set beats clear
      else if (wr_i && wdata_i[i])     evt_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i[ST_W-1:EVT_N];
  end

  assign status_o = {en_q, evt_q};
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_W      = 10,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned DEFAULT_DIV = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_tick_o,
  output logic              irq_alarm_o
);
  localparam int unsigned TD_W = DIV_W + TRIM_W;

  reg_sel_e          sel;
  logic              tick_w, load_w, match_w, stat_wr;
  logic [DATA_W-1:0] count_w, alarm_q;
  logic [TD_W-1:0]   trimdiv_q;
  logic [ST_W-1:0]   status_w;

  assign sel     = reg_sel_e'(addr_i);
  assign load_w  = we_i && (sel == REG_COUNT);
  assign stat_wr = we_i && (sel == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q   <= '0;
      trimdiv_q <= '0;
    end else if (we_i) begin
      if (sel == REG_ALARM) alarm_q   <= wdata_i;
      if (sel == REG_TRIM)  trimdiv_q <= wdata_i[TD_W-1:0];
    end
  end

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W),
    .TRIM_PERIOD(TRIM_PERIOD), .DEFAULT_DIV(DEFAULT_DIV)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (trimdiv_q[DIV_W-1:0]),
    .trim_i (trimdiv_q[TD_W-1:DIV_W]),
    .tick_o (tick_w)
  );

  rtc_sec_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .load_i     (load_w),
    .load_val_i (wdata_i),
    .alarm_i    (alarm_q),
    .count_o    (count_w),
    .match_o    (match_w)
  );

  logic [EVT_N-1:0] evt_set;
  assign evt_set[ST_AL] = match_w;
  assign evt_set[ST_HZ] = tick_w;

  rtc_status u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .wr_i     (stat_wr),
    .wdata_i  (wdata_i[ST_W-1:0]),
    .status_o (status_w)
  );

  always_comb begin
    unique case (sel)
      REG_COUNT: rdata_o = count_w;
      REG_ALARM: rdata_o = alarm_q;
      REG_STAT:  rdata_o = DATA_W'(status_w);
      default:   rdata_o = DATA_W'(trimdiv_q);
    endcase
  end

  assign irq_alarm_o = status_w[ST_AL] & status_w[EVT_N + ST_AL];
  assign irq_tick_o  = status_w[ST_HZ] & status_w[EVT_N + ST_HZ];
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             load_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] alarm_i,
  input logic             flag_al_i,
  input logic             flag_hz_i
);
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (count_i == $past(count_i) + CNT_W'(1)));

  p_count_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(count_i));

  p_hz_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> flag_hz_i);

  p_alarm_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && (count_i + CNT_W'(1) == alarm_i)) |=> flag_al_i);

  p_alarm_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_al_i) |-> $past(tick_i));
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.CNT_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_w),
  .load_i    (load_w),
  .count_i   (count_w),
  .alarm_i   (alarm_q),
  .flag_al_i (status_w[0]),
  .flag_hz_i (status_w[1])
);

// File: tb/sim_rtc_sec_alarm.sv
`timescale 1ns/1ps
module sim_rtc_sec_alarm;
  localparam int TP = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_tick_o, irq_alarm_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rtc_sec_alarm #(.TRIM_PERIOD(TP)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_tick_o(irq_tick_o), .irq_alarm_o(irq_alarm_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end aligned just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic meas(output int n);
    logic [31:0] prev, cur;
    rd(2'd0, prev);
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk_i);
      n++;
      rd(2'd0, cur);
      if (cur != prev) break;
    end
  endtask

  task automatic sync();
    int n;
    meas(n);
  endtask

  initial begin
    #(190000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    int p[8];

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    rd(2'd3, v); chk("R1 trimdiv", v, 0);
    chk("R1 irqs", {30'd0, irq_tick_o, irq_alarm_o}, 0);

    // R2 readback
    wr(2'd1, 32'hDEADBEEF); rd(2'd1, v); chk("R2 alarm", v, 32'hDEADBEEF);
    wr(2'd3, 32'hFFFFFFFF); rd(2'd3, v); chk("R2 trimdiv mask", v, 32'h03FFFFFF);
    wr(2'd3, 32'h00020005); rd(2'd3, v); chk("R2 trimdiv fields", v, 32'h00020005);

    // R3 sweep over divide values, no trim
    for (int d = 1; d <= 8; d++) begin
      wr(2'd3, d);
      sync();
      for (int k = 0; k < 2; k++) begin
        meas(n);
        chk($sformatf("R3 period div=%0d", d), n, d + 1);
      end
    end

    // R5 trim: one long period every TP periods
    foreach (p[i]) p[i] = 0;
    for (int t = 1; t <= 5; t += 2) begin
      int longs, first, second;
      wr(2'd3, (t << 16) | 3);
      sync();
      for (int i = 0; i < 8; i++) meas(p[i]);
      longs = 0; first = -1; second = -1;
      for (int i = 0; i < 8; i++) begin
        if (p[i] == 4 + t) begin
          longs++;
          if (first < 0) first = i; else second = i;
        end else if (p[i] != 4) begin
          chk($sformatf("R5 short period trim=%0d idx=%0d", t, i), p[i], 4);
        end
      end
      chk($sformatf("R5 long count trim=%0d", t), longs, 2);
      chk($sformatf("R5 long spacing trim=%0d", t), second - first, TP);
    end

    // R6 load, then collision of load and tick (period 4)
    wr(2'd3, 3);
    sync();
    wr(2'd0, 32'd100); rd(2'd0, v); chk("R6 load", v, 100);
    sync(); rd(2'd0, v); chk("R6 resume", v, 101);
    sync();
    repeat (3) @(negedge clk_i);
    wr(2'd0, 32'd500);
    rd(2'd0, v); chk("R6 load beats tick", v, 500);
    meas(n); chk("R6 next tick spacing", n, 4);
    rd(2'd0, v); chk("R6 count after collision", v, 501);

    // R10 set beats clear on the tick flag
    sync();
    repeat (3) @(negedge clk_i);
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk("R10 hz set beats clear", v[1], 1);
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk("R10 hz clear alone", v[1], 0);

    // R7 tick flag, slower divide
    wr(2'd3, 50);
    sync();
    rd(2'd2, v); chk("R7 hz flag set", v, 32'h2);
    chk("R9 irq_tick off when disabled", irq_tick_o, 0);
    wr(2'd2, 32'h0); rd(2'd2, v); chk("R7 write 0 keeps flag", v, 32'h2);
    wr(2'd2, 32'h2); rd(2'd2, v); chk("R7 w1c clears", v, 32'h0);

    // R9 enables and irq gating
    wr(2'd2, 32'h8); rd(2'd2, v); chk("R9 enable readback", v, 32'h8);
    chk("R9 irq_tick low, flag clear", irq_tick_o, 0);
    sync();
    rd(2'd2, v); chk("R9 status after tick", v, 32'hA);
    chk("R9 irq_tick high", irq_tick_o, 1);
    wr(2'd2, 32'h0);
    chk("R9 irq_tick low after disable", irq_tick_o, 0);
    rd(2'd2, v); chk("R9 flag kept after disable", v, 32'h2);

    // R8 alarm
    sync();
    wr(2'd2, 32'h3);
    wr(2'd1, 32'd300);
    wr(2'd0, 32'd300);
    rd(2'd2, v); chk("R8 load to alarm value does not fire", v[0], 0);
    wr(2'd1, 32'd302);
    wr(2'd2, 32'h4);
    sync();
    rd(2'd0, v); chk("R8 count 301", v, 301);
    rd(2'd2, v); chk("R8 no alarm at 301", v[0], 0);
    chk("R9 irq_alarm low", irq_alarm_o, 0);
    sync();
    rd(2'd2, v); chk("R8 alarm at 302", v[0], 1);
    chk("R9 irq_alarm high", irq_alarm_o, 1);
    wr(2'd2, 32'h5);
    rd(2'd2, v); chk("R8 alarm cleared", v[0], 0);
    chk("R9 irq_alarm low after clear", irq_alarm_o, 0);
    rd(2'd2, v); chk("R9 alarm enable kept", v[2], 1);

    // R4 zero divide selects 32768
    wr(2'd3, 0);
    sync();
    meas(n); chk("R4 default period", n, 32768);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule